// File: doc/BRIEF.md
# Multi-Mode PWM and Capture Timer Slice

This block is one slice of a timer unit; a unit places four of them side by side, each with its own setup. One counter, one prescaler and one compare path are shared by three modes. The first gives two separate 8-bit PWM outputs, one from each byte of the counter. The second joins the bytes into a single 16-bit PWM output. The third runs a 16-bit free-running counter with two input capture channels. Each capture channel latches the counter value when its input shows the selected edge.

Software reaches the slice through a register port. Writes are synchronous. Reads are combinational from a separate read address. The period and duty settings are held in shadow registers and move into the active copies at a period boundary. A changed setting therefore never cuts a pulse short. Capture events set sticky flags that software clears by writing 1. A capture that arrives while its flag is still set also marks an overrun. The interrupt output is high while any capture flag is set.

Top module: `vtimer_slice`

## Requirements
- R1: Register map by 3-bit address. 0 control: bits [1:0] mode, bit 2 run, bits [5:4] edge select for channel 0, bits [7:6] edge select for channel 1. 1 prescaler (8 bits). 2 period shadow. 3 duty shadow. 4 capture 0. 5 capture 1. 6 status: bit 0 and bit 1 are the capture flags of channels 0 and 1, bit 2 and bit 3 their overrun flags. 7 live counter. After reset every register, both PWM outputs and the interrupt read zero.
- R2: With prescaler value N and the counter running, the counter advances once every N+1 clocks.
- R3: Mode 0 (dual 8-bit). The low byte counts from 0 to period[7:0] and wraps. The high byte counts from 0 to period[15:8] and wraps. pwm_out[0] is high while the low byte is below duty[7:0]. pwm_out[1] is high while the high byte is below duty[15:8].
- R4: Mode 1 (single 16-bit). The full counter counts from 0 to period and wraps. pwm_out[0] is high while the counter is below duty. pwm_out[1] stays low.
- R5: A duty value of 0 keeps an output low for the whole period. A duty value above the period keeps it high for the whole period.
- R6: A write to the period or duty shadow takes effect at the next wrap of the counter that uses it. While the counter is stopped, the shadow takes effect at once.
- R7: Mode 2 (capture). The counter runs freely through all 16 bits. Each channel input passes through two synchronizing flops. An edge-select code of 01 captures on rising edges, 10 on falling edges, 11 on both and 00 on none. Edges that are not selected leave the flag and the capture register unchanged.
- R8: A capture loads the counter value into the channel's capture register and sets the channel's sticky flag. Writing 1 to a flag bit clears it. cap_irq is high while either capture flag is set.
- R9: A capture on a channel whose flag is still set, with no clear in the same cycle, sets that channel's overrun flag. Writing 1 to the overrun bit clears it.
- R10: A control write that changes the mode clears the run bit and sets the counter to zero, whatever run value is written. A control write that keeps the mode takes the written run bit. Whenever the run bit is clear, the counter and the prescaler hold at zero.
- R11: Both PWM outputs are low in capture mode, in mode 3 and while the slice is stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Read data for rd_addr, combinational |
| cap_in | input | 2 | Capture inputs, channel 0 in bit 0 |
| pwm_out | output | 2 | PWM outputs |
| cap_irq | output | 1 | Capture interrupt, high while any capture flag is set |

## Verification
The PWM paths are checked by counting high samples over whole multiples of the period. This makes the result independent of phase. The tests cover two unequal byte periods, a prescaler of 1, a 16-bit period and duty values of 0 and above the period. Together these separate byte splitting, prescaler division, compare direction and saturation. One duty write lands in the middle of a period: the output must keep the old pulse until the wrap and then show the new ratio. Capture uses a slow prescaler so that the latched value is known. It is tried with rising-only, falling-only and both-edge selects, so edges that must be ignored are told apart from edges that must be taken. Back-to-back captures without a clear exercise the overrun flag.

// File: rtl/vtimer_slice.sv
module vtimer_slice #(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [CW-1:0] rd_data,
  input  logic [1:0]    cap_in,
  output logic [1:0]    pwm_out,
  output logic          cap_irq
);
  localparam int HW = CW / 2;
  localparam logic [1:0] M_DUAL = 2'd0;
  localparam logic [1:0] M_WIDE = 2'd1;
  localparam logic [1:0] M_CAP  = 2'd2;

  logic [1:0]    mode;
  logic          run;
  logic [3:0]    esel;
  logic [PW-1:0] presc, pdiv;
  logic [CW-1:0] per_sh, duty_sh, per_act, duty_act, cnt, cap0, cap1;
  logic [1:0]    flag, ovr, s1, s2, s3, ev, hit, fclr, oclr;

  wire active   = run && (mode != 2'd3);
  wire tick     = active && (pdiv == presc);
  wire ctrl_wr  = wr_en && (wr_addr == 3'd0);
  wire mode_chg = ctrl_wr && (wr_data[1:0] != mode);
  wire stat_wr  = wr_en && (wr_addr == 3'd6);
  wire wrap_lo  = cnt[HW-1:0] == per_act[HW-1:0];
  wire wrap_hi  = cnt[CW-1:HW] == per_act[CW-1:HW];
  wire wrap_w   = cnt == per_act;
  wire load_lo  = !active || (tick && ((mode == M_DUAL && wrap_lo) || (mode == M_WIDE && wrap_w)));
  wire load_hi  = !active || (tick && ((mode == M_DUAL && wrap_hi) || (mode == M_WIDE && wrap_w)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= M_DUAL; run <= 1'b0; esel <= '0; presc <= '0;
      per_sh <= '0; duty_sh <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: begin
          mode <= wr_data[1:0];
          run  <= mode_chg ? 1'b0 : wr_data[2];
          esel <= wr_data[7:4];
        end
        3'd1: presc   <= wr_data[PW-1:0];
        3'd2: per_sh  <= wr_data;
        3'd3: duty_sh <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pdiv <= '0; cnt <= '0;
    end else if (!active || mode_chg) begin
      pdiv <= '0; cnt <= '0;
    end else begin
      pdiv <= tick ? '0 : pdiv + 1'b1;
      if (tick) begin
        case (mode)
          M_DUAL: begin
            cnt[HW-1:0]  <= wrap_lo ? '0 : cnt[HW-1:0] + 1'b1;
            cnt[CW-1:HW] <= wrap_hi ? '0 : cnt[CW-1:HW] + 1'b1;
          end
          M_WIDE:  cnt <= wrap_w ? '0 : cnt + 1'b1;
          default: cnt <= cnt + 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_act <= '0; duty_act <= '0;
    end else begin
      if (load_lo) begin
        per_act[HW-1:0]  <= per_sh[HW-1:0];
        duty_act[HW-1:0] <= duty_sh[HW-1:0];
      end
      if (load_hi) begin
        per_act[CW-1:HW]  <= per_sh[CW-1:HW];
        duty_act[CW-1:HW] <= duty_sh[CW-1:HW];
      end
    end
  end

  wire lo_on   = cnt[HW-1:0] < duty_act[HW-1:0];
  wire hi_on   = cnt[CW-1:HW] < duty_act[CW-1:HW];
  wire wide_on = cnt < duty_act;

  assign pwm_out[0] = active && ((mode == M_DUAL) ? lo_on : (mode == M_WIDE) ? wide_on : 1'b0);
  assign pwm_out[1] = active && (mode == M_DUAL) && hi_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= cap_in; s2 <= s1; s3 <= s2;
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_cap
    assign ev[i]   = (s2[i] & ~s3[i] & esel[2*i]) | (~s2[i] & s3[i] & esel[2*i+1]);
    assign hit[i]  = ev[i] && active && (mode == M_CAP);
    assign fclr[i] = stat_wr && wr_data[i];
    assign oclr[i] = stat_wr && wr_data[i+2];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flag[i] <= 1'b0; ovr[i] <= 1'b0;
      end else begin
        flag[i] <= hit[i] ? 1'b1 : (fclr[i] ? 1'b0 : flag[i]);
        ovr[i]  <= (hit[i] && flag[i] && !fclr[i]) ? 1'b1 : (oclr[i] ? 1'b0 : ovr[i]);
      end
    end

    assert_overrun_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr[i]) |-> flag[i]);
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !fclr[i]) |=> flag[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap0 <= '0; cap1 <= '0;
    end else begin
      if (hit[0]) cap0 <= cnt;
      if (hit[1]) cap1 <= cnt;
    end
  end

  assign cap_irq = |flag;

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = {{(CW-8){1'b0}}, esel, 1'b0, run, mode};
      3'd1:    rd_data = {{(CW-PW){1'b0}}, presc};
      3'd2:    rd_data = per_sh;
      3'd3:    rd_data = duty_sh;
      3'd4:    rd_data = cap0;
      3'd5:    rd_data = cap1;
      3'd6:    rd_data = {{(CW-4){1'b0}}, ovr, flag};
      default: rd_data = cnt;
    endcase
  end

  assert_mode_change_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (cnt == '0 && !run));
  assert_stopped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt == '0));
  assert_presc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick && !mode_chg) |=> $stable(cnt));
  assert_period_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mode == M_WIDE) |-> (cnt <= per_act));
  assert_capture_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> (cap0 == $past(cnt)));
  assert_quiet_in_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_CAP) |-> (pwm_out == 2'b00));
endmodule

// File: tb/tb_vtimer_slice.sv
module tb_vtimer_slice;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [1:0]  cap_in = '0;
  logic [1:0]  pwm_out;
  logic        cap_irq;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  vtimer_slice dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cap_in(cap_in), .pwm_out(pwm_out), .cap_irq(cap_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic count_high(input int idx, input int n, output int hi);
    hi = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_out[idx]) hi++;
    end
  endtask

  task automatic wait_count(input int target);
    int v;
    v = -1;
    while (v != target) rd(3'd7, v);
  endtask

  task automatic t_reset;
    int v;
    rd(3'd7, v); chk("R1 counter after reset", v, 0);
    rd(3'd0, v); chk("R1 control after reset", v, 0);
    rd(3'd6, v); chk("R1 status after reset", v, 0);
    chk("R1 pwm after reset", int'(pwm_out), 0);
    chk("R1 irq after reset", int'(cap_irq), 0);
  endtask

  task automatic t_dual8;
    int hi;
    wr(3'd1, 16'd0);
    wr(3'd2, {8'd4, 8'd9});
    wr(3'd3, {8'd5, 8'd3});
    wr(3'd0, 16'h0004);
    count_high(0, 100, hi); chk("R3 low byte channel high count", hi, 30);
    count_high(1, 100, hi); chk("R5 duty above period stays high", hi, 100);
    wr(3'd0, 16'h0000);
    wr(3'd3, {8'd2, 8'd3});
    wr(3'd0, 16'h0004);
    count_high(1, 100, hi); chk("R3 high byte channel high count", hi, 40);
  endtask

  task automatic t_prescale;
    int hi, c1, c2;
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'd1);
    wr(3'd0, 16'h0004);
    count_high(0, 200, hi); chk("R2 prescaler 1 doubles period", hi, 60);
    wr(3'd0, 16'h0001);
    wr(3'd1, 16'd4);
    wr(3'd2, 16'd999);
    wr(3'd0, 16'h0005);
    rd(3'd7, c1);
    repeat (49) @(negedge clk);
    rd(3'd7, c2);
    chk("R2 prescaler 4 ticks in 50 clocks", c2 - c1, 10);
  endtask

  task automatic t_wide;
    int hi, v;
    wr(3'd0, 16'h0002);
    wr(3'd0, 16'h0001);
    rd(3'd0, v); chk("R10 mode change clears run", v & 4, 0);
    wr(3'd1, 16'd0);
    wr(3'd2, 16'd299);
    wr(3'd3, 16'd100);
    wr(3'd0, 16'h0005);
    count_high(0, 300, hi); chk("R4 16-bit high count", hi, 100);
    count_high(1, 300, hi); chk("R4 second output low in 16-bit mode", hi, 0);
  endtask

  task automatic t_extremes;
    int hi;
    wr(3'd0, 16'h0001);
    count_high(0, 20, hi); chk("R11 stopped output low", hi, 0);
    wr(3'd3, 16'd0);
    wr(3'd0, 16'h0005);
    count_high(0, 300, hi); chk("R5 duty zero stays low", hi, 0);
    wr(3'd0, 16'h0001);
    wr(3'd3, 16'd400);
    wr(3'd0, 16'h0005);
    count_high(0, 300, hi); chk("R5 duty above period 16-bit", hi, 300);
  endtask

  task automatic t_buffer;
    int hi, v;
    wr(3'd0, 16'h0001);
    wr(3'd2, 16'd999);
    wr(3'd3, 16'd500);
    wr(3'd0, 16'h0005);
    repeat (250) @(negedge clk);
    wr(3'd3, 16'd100);
    count_high(0, 50, hi); chk("R6 old duty kept until wrap", hi, 50);
    v = 999;
    while (v > 50) rd(3'd7, v);
    count_high(0, 1000, hi); chk("R6 new duty after wrap", hi, 100);
  endtask

  task automatic t_mode_change;
    int v;
    wr(3'd0, 16'h0006);
    rd(3'd7, v); chk("R10 counter cleared on mode change", v, 0);
    rd(3'd0, v); chk("R10 run cleared on mode change", v & 4, 0);
    repeat (50) @(negedge clk);
    rd(3'd7, v); chk("R10 counter stays zero while stopped", v, 0);
  endtask

  task automatic t_capture;
    int v;
    wr(3'd1, 16'd255);
    wr(3'd0, 16'h0096);
    wait_count(3);
    repeat (20) @(negedge clk);
    cap_in[0] = 1'b1;
    repeat (10) @(negedge clk);
    rd(3'd4, v); chk("R7 rising capture value", v, 3);
    rd(3'd6, v); chk("R8 flag 0 set", v, 1);
    chk("R8 irq raised", int'(cap_irq), 1);
    chk("R11 pwm low in capture mode", int'(pwm_out), 0);
    wr(3'd6, 16'h0001);
    rd(3'd6, v); chk("R8 flag cleared by write 1", v, 0);
    chk("R8 irq dropped", int'(cap_irq), 0);
    wait_count(5);
    repeat (20) @(negedge clk);
    cap_in[1] = 1'b1;
    repeat (10) @(negedge clk);
    rd(3'd6, v); chk("R7 rising edge ignored on falling-only channel", v, 0);
    rd(3'd5, v); chk("R7 ignored edge leaves capture 1", v, 0);
    cap_in[1] = 1'b0;
    repeat (10) @(negedge clk);
    rd(3'd6, v); chk("R7 falling edge captured on channel 1", v, 2);
    rd(3'd5, v); chk("R7 falling capture value", v, 5);
    cap_in[0] = 1'b0;
    repeat (10) @(negedge clk);
    rd(3'd6, v); chk("R7 falling edge ignored on rising-only channel", v & 1, 0);
    wr(3'd6, 16'h000F);
  endtask

  task automatic t_overrun;
    int v;
    wr(3'd0, 16'h00B6);
    rd(3'd0, v); chk("R10 same-mode write keeps run", v & 4, 4);
    cap_in[0] = 1'b1;
    repeat (10) @(negedge clk);
    cap_in[0] = 1'b0;
    repeat (10) @(negedge clk);
    rd(3'd6, v); chk("R9 overrun on second capture", v, 5);
    chk("R8 irq with flag set", int'(cap_irq), 1);
    wr(3'd6, 16'h000F);
    rd(3'd6, v); chk("R9 overrun and flag cleared", v, 0);
    chk("R8 irq low after clear", int'(cap_irq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_dual8();
    t_prescale();
    t_wide();
    t_extremes();
    t_buffer();
    t_mode_change();
    t_capture();
    t_overrun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule